// File: doc/BRIEF.md
# Floating-Point NaN-Boxing Operand Unit

This block sits between a 64-bit floating-point register file and the arithmetic datapath. It enforces the rules for keeping 32-bit single-precision values inside 64-bit registers. On the read side, each source register value is turned into an operand. The choice depends on the operand format (single or double) and on the operation class (compute or transfer). A single-precision compute operand is accepted only if its upper half is all ones. Otherwise it is replaced by the 32-bit canonical NaN.

On the write side, a single-precision result is padded with ones in the upper half. This covers compute results, 32-bit loads and moves from integer registers. A double-precision value passes through untouched. A separate transfer-out path serves stores and moves to integer registers. For single precision it forwards only the low 32 bits and discards the upper half. For double precision it forwards all 64 bits untouched.

The unit is purely combinational. Arithmetic, rounding and the register file itself live elsewhere.

Top module: `fp_nanbox_unit`

## Requirements
- R1: When `wr_fmt_i` is 0 (single), `wr_data_o[63:32]` is all ones and `wr_data_o[31:0]` equals `wr_res_i[31:0]`, whatever `wr_res_i[63:32]` holds.
- R2: When `wr_fmt_i` is 1 (double), `wr_data_o` equals `wr_res_i` bit for bit, NaN payloads included.
- R3: When `st_fmt_i` is 0 (single), `st_data_o[31:0]` equals `st_reg_i[31:0]` and `st_data_o[63:32]` is zero, whatever `st_reg_i[63:32]` holds.
- R4: With `rd_fmt_i`=0 and `rd_cls_i`=0 (compute), an operand whose bits 63:32 are all ones yields `rd_opnd_o` = {32'h0, bits 31:0} and `rd_box_ok_o` = 1.
- R5: With `rd_fmt_i`=0 and `rd_cls_i`=0, an operand whose bits 63:32 are not all ones (even one bit clear) yields `rd_opnd_o` = 64'h0000_0000_7FC0_0000 and `rd_box_ok_o` = 0.
- R6: With `rd_fmt_i`=0 and `rd_cls_i`=1 (transfer), the operand is {32'h0, bits 31:0} and `rd_box_ok_o` = 1, whatever bits 63:32 hold.
- R7: With `rd_fmt_i`=1, each operand equals its register value bit for bit and `rd_box_ok_o` = 1, in either class.
- R8: When `st_fmt_i` is 1, `st_data_o` equals `st_reg_i` bit for bit.
- R9: A single-precision write value, viewed as 64 bits, is a negative quiet NaN: bits 63:51 are all ones.
- R10: Each of the three read operands is checked and replaced on its own. Operand k uses slice k of `rd_reg_i` and drives slice k of `rd_opnd_o` and bit k of `rd_box_ok_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rd_reg_i | input | 3x64 | Source register values, one 64-bit slice per operand |
| rd_fmt_i | input | 1 | Read operand format: 0 single, 1 double |
| rd_cls_i | input | 1 | Read operation class: 0 compute, 1 transfer |
| rd_opnd_o | output | 3x64 | Operands to the datapath; single values in bits 31:0 |
| rd_box_ok_o | output | 3 | Per-operand flag: 1 when the value was accepted, 0 when replaced by the canonical NaN |
| wr_res_i | input | 64 | Result or incoming transfer value to be written |
| wr_fmt_i | input | 1 | Write format: 0 single, 1 double |
| wr_data_o | output | 64 | Register write value |
| st_reg_i | input | 64 | Register value leaving the register file |
| st_fmt_i | input | 1 | Transfer-out format: 0 single, 1 double |
| st_data_o | output | 64 | Value to memory or integer register |

## Verification
Read operands are tried with correctly boxed singles, including infinity and signalling-NaN bit patterns. They are also tried with upper halves that are zero, all ones except bit 32, and all ones except bit 63. Together these show that the box check needs every upper bit set. A mixed vector with good and bad operands in one call shows that the three decisions are made independently. Double inputs carry signalling-NaN payloads and upper halves that would fail a single-precision check, which shows that the box check applies only to single precision. Transfer cases use non-boxed upper garbage, which separates the transfer behaviour from the compute behaviour on the read path and the store path.

// File: rtl/fp_nanbox_pkg.sv
package fp_nanbox_pkg;
  localparam int unsigned FLEN     = 64;
  localparam int unsigned SLEN     = 32;
  localparam int unsigned NUM_OPS  = 3;
  localparam logic [SLEN-1:0] CANON_NAN_S = 32'h7FC0_0000;

  typedef enum logic {FMT_S = 1'b0, FMT_D = 1'b1} fmt_e;
  typedef enum logic {CLS_COMPUTE = 1'b0, CLS_XFER = 1'b1} cls_e;
endpackage

// File: rtl/fp_nanbox_unbox.sv
module fp_nanbox_unbox
  import fp_nanbox_pkg::*;
#(
  parameter int unsigned    FLEN_P = FLEN,
  parameter int unsigned    SLEN_P = SLEN,
  parameter logic [SLEN_P-1:0] CANON_P = CANON_NAN_S
) (
  input  logic [FLEN_P-1:0] reg_i,
  input  logic              fmt_i,
  input  logic              cls_i,
  output logic [FLEN_P-1:0] opnd_o,
  output logic              ok_o
);
  localparam int unsigned PAD = FLEN_P - SLEN_P;

  fmt_e fmt;
  cls_e cls;
  logic upper_ones;

  assign fmt        = fmt_e'(fmt_i);
  assign cls        = cls_e'(cls_i);
  assign upper_ones = &reg_i[FLEN_P-1:SLEN_P];

  always_comb begin
    opnd_o = reg_i;
    ok_o   = 1'b1;
    if (fmt == FMT_S) begin
      if (cls == CLS_XFER || upper_ones) begin
        opnd_o = {{PAD{1'b0}}, reg_i[SLEN_P-1:0]};
      end else begin
        opnd_o = {{PAD{1'b0}}, CANON_P};
        ok_o   = 1'b0;
      end
    end
  end

  always_comb begin
    if (!$isunknown({reg_i, fmt_i, cls_i})) begin
      // R7: double operands pass untouched
      a_r7_double_passthru: assert (fmt_i == 1'b0 || (opnd_o == reg_i && ok_o));
      // R6: transfer singles keep low half
      a_r6_xfer_low_kept: assert (fmt_i || !cls_i || (opnd_o[SLEN_P-1:0] == reg_i[SLEN_P-1:0] && ok_o));
      // R5: rejected operand carries the canonical NaN
      a_r5_reject_is_nan: assert (ok_o || opnd_o[SLEN_P-1:0] == CANON_P);
      // R4: single operands never leak upper bits
      a_r4_single_upper_clear: assert (fmt_i || opnd_o[FLEN_P-1:SLEN_P] == '0);
    end
  end
endmodule

// File: rtl/fp_nanbox_box.sv
module fp_nanbox_box
  import fp_nanbox_pkg::*;
#(
  parameter int unsigned FLEN_P = FLEN,
  parameter int unsigned SLEN_P = SLEN
) (
  input  logic [FLEN_P-1:0] res_i,
  input  logic              fmt_i,
  output logic [FLEN_P-1:0] wr_o
);
  localparam int unsigned PAD = FLEN_P - SLEN_P;
  localparam int unsigned QNAN_TOP = (PAD < 13) ? PAD : 13;

  always_comb begin
    if (fmt_e'(fmt_i) == FMT_S) wr_o = {{PAD{1'b1}}, res_i[SLEN_P-1:0]};
    else                        wr_o = res_i;
  end

  always_comb begin
    if (!$isunknown({res_i, fmt_i})) begin
      // R9: boxed single reads as negative quiet NaN
      a_r9_box_neg_qnan: assert (fmt_i || &wr_o[FLEN_P-1 -: QNAN_TOP]);
      // R1: payload kept in low half
      a_r1_box_low_kept: assert (fmt_i || wr_o[SLEN_P-1:0] == res_i[SLEN_P-1:0]);
      // R2: double write unchanged
      a_r2_double_write: assert (!fmt_i || wr_o == res_i);
    end
  end
endmodule

// File: rtl/fp_nanbox_xfer_out.sv
module fp_nanbox_xfer_out
  import fp_nanbox_pkg::*;
#(
  parameter int unsigned FLEN_P = FLEN,
  parameter int unsigned SLEN_P = SLEN
) (
  input  logic [FLEN_P-1:0] reg_i,
  input  logic              fmt_i,
  output logic [FLEN_P-1:0] data_o
);
  localparam int unsigned PAD = FLEN_P - SLEN_P;

  assign data_o = (fmt_e'(fmt_i) == FMT_D) ? reg_i : {{PAD{1'b0}}, reg_i[SLEN_P-1:0]};

  always_comb begin
    if (!$isunknown({reg_i, fmt_i})) begin
      // R3: single store drops the upper half
      a_r3_store_single: assert (fmt_i || (data_o[SLEN_P-1:0] == reg_i[SLEN_P-1:0] && data_o[FLEN_P-1:SLEN_P] == '0));
      // R8: double store unchanged
      a_r8_store_double: assert (!fmt_i || data_o == reg_i);
    end
  end
endmodule

// File: rtl/fp_nanbox_unit.sv
module fp_nanbox_unit
  import fp_nanbox_pkg::*;
#(
  parameter int unsigned FLEN_P = FLEN,
  parameter int unsigned SLEN_P = SLEN,
  parameter int unsigned OPS_P  = NUM_OPS,
  parameter logic [SLEN_P-1:0] CANON_P = CANON_NAN_S
) (
  input  logic [OPS_P-1:0][FLEN_P-1:0] rd_reg_i,
  input  logic                         rd_fmt_i,
  input  logic                         rd_cls_i,
  output logic [OPS_P-1:0][FLEN_P-1:0] rd_opnd_o,
  output logic [OPS_P-1:0]             rd_box_ok_o,
  input  logic [FLEN_P-1:0]            wr_res_i,
  input  logic                         wr_fmt_i,
  output logic [FLEN_P-1:0]            wr_data_o,
  input  logic [FLEN_P-1:0]            st_reg_i,
  input  logic                         st_fmt_i,
  output logic [FLEN_P-1:0]            st_data_o
);
  // R10: one independent unbox slice per operand
  for (genvar k = 0; k < OPS_P; k++) begin : g_op
    fp_nanbox_unbox #(
      .FLEN_P (FLEN_P),
      .SLEN_P (SLEN_P),
      .CANON_P(CANON_P)
    ) u_unbox (
      .reg_i (rd_reg_i[k]),
      .fmt_i (rd_fmt_i),
      .cls_i (rd_cls_i),
      .opnd_o(rd_opnd_o[k]),
      .ok_o  (rd_box_ok_o[k])
    );
  end

  fp_nanbox_box #(.FLEN_P(FLEN_P), .SLEN_P(SLEN_P)) u_box (
    .res_i(wr_res_i),
    .fmt_i(wr_fmt_i),
    .wr_o (wr_data_o)
  );

  fp_nanbox_xfer_out #(.FLEN_P(FLEN_P), .SLEN_P(SLEN_P)) u_xout (
    .reg_i (st_reg_i),
    .fmt_i (st_fmt_i),
    .data_o(st_data_o)
  );
endmodule

// File: tb/fp_nanbox_unit_tb_top.sv
module fp_nanbox_unit_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [2:0][63:0] rd_reg;
  logic             rd_fmt, rd_cls;
  logic [2:0][63:0] rd_opnd;
  logic [2:0]       rd_ok;
  logic [63:0]      wr_res, wr_data, st_reg, st_data;
  logic             wr_fmt, st_fmt;

  fp_nanbox_unit dut_i (
    .rd_reg_i(rd_reg), .rd_fmt_i(rd_fmt), .rd_cls_i(rd_cls),
    .rd_opnd_o(rd_opnd), .rd_box_ok_o(rd_ok),
    .wr_res_i(wr_res), .wr_fmt_i(wr_fmt), .wr_data_o(wr_data),
    .st_reg_i(st_reg), .st_fmt_i(st_fmt), .st_data_o(st_data)
  );

  typedef struct {
    string            tag;
    logic [2:0][63:0] opnd;
    logic [2:0]       ok;
    logic [63:0]      wr;
    logic [63:0]      st;
  } exp_t;

  exp_t sb_q[$];
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [31:0] QNAN32 = 32'h7FC0_0000;

  function automatic logic [64:0] ref_read(logic [63:0] r, logic fmt, logic cls);
    if (fmt) return {1'b1, r};
    if (cls || r[63:32] == 32'hFFFF_FFFF) return {1'b1, 32'h0, r[31:0]};
    return {1'b0, 32'h0, QNAN32};
  endfunction

  task automatic drive(input string tag, input logic [63:0] a, b, c,
                       input logic fmt, cls, input logic [63:0] wres,
                       input logic wfmt, input logic [63:0] sreg, input logic sfmt);
    exp_t e;
    logic [64:0] t;
    @(posedge clk);
    #1;
    rd_reg = '{c, b, a};
    rd_fmt = fmt; rd_cls = cls;
    wr_res = wres; wr_fmt = wfmt;
    st_reg = sreg; st_fmt = sfmt;
    e.tag = tag;
    for (int k = 0; k < 3; k++) begin
      t = ref_read(rd_reg[k], fmt, cls);
      e.ok[k]   = t[64];
      e.opnd[k] = t[63:0];
    end
    e.wr = wfmt ? wres : {32'hFFFF_FFFF, wres[31:0]};
    e.st = sfmt ? sreg : {32'h0, sreg[31:0]};
    sb_q.push_back(e);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_ni && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_run++;
      if (rd_opnd !== e.opnd || rd_ok !== e.ok || wr_data !== e.wr || st_data !== e.st) begin
        n_fail++;
        $display("FAIL %s: opnd=%h ok=%b wr=%h st=%h expected opnd=%h ok=%b wr=%h st=%h",
                 e.tag, rd_opnd, rd_ok, wr_data, st_data, e.opnd, e.ok, e.wr, e.st);
      end
    end
  end

  // watchdog
  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run=%0d expected completion", n_run);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rd_reg = '0; rd_fmt = 1'b0; rd_cls = 1'b0;
    wr_res = '0; wr_fmt = 1'b0; st_reg = '0; st_fmt = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // reset-state inputs: zeros, single compute -> R5 replacement, R1 boxing
    drive("R5 idle zeros", 64'h0, 64'h0, 64'h0, 1'b0, 1'b0, 64'h0, 1'b0, 64'h0, 1'b0);
    drive("R4 boxed singles", 64'hFFFF_FFFF_3F80_0000, 64'hFFFF_FFFF_C049_0FDB,
          64'hFFFF_FFFF_7F80_0001, 1'b0, 1'b0, 64'h0, 1'b1, 64'h0, 1'b1);
    drive("R4 boxed inf", 64'hFFFF_FFFF_7F80_0000, 64'hFFFF_FFFF_FF80_0000,
          64'hFFFF_FFFF_0000_0001, 1'b0, 1'b0, 64'h0, 1'b1, 64'h0, 1'b1);
    drive("R5 bad upper", 64'h0000_0000_3F80_0000, 64'hFFFF_FFFE_3F80_0000,
          64'h7FFF_FFFF_3F80_0000, 1'b0, 1'b0, 64'h0, 1'b1, 64'h0, 1'b1);
    drive("R10 mixed", 64'hFFFF_FFFF_4000_0000, 64'h8000_0000_4000_0000,
          64'hFFFF_FFFF_BF80_0000, 1'b0, 1'b0, 64'h0, 1'b1, 64'h0, 1'b1);
    drive("R10 mixed b", 64'h1234_5678_4000_0000, 64'hFFFF_FFFF_4000_0000,
          64'hFFFF_0000_BF80_0000, 1'b0, 1'b0, 64'h0, 1'b1, 64'h0, 1'b1);
    drive("R6 xfer junk", 64'h0000_0000_1234_5678, 64'hDEAD_BEEF_7F80_0001,
          64'hFFFF_FFFF_CAFE_F00D, 1'b0, 1'b1, 64'h0, 1'b1, 64'h0, 1'b1);
    drive("R7 double compute", 64'h7FF0_0000_0000_0001, 64'h0000_0000_3F80_0000,
          64'h4009_21FB_5444_2D18, 1'b1, 1'b0, 64'h0, 1'b1, 64'h0, 1'b1);
    drive("R7 double xfer", 64'hFFF4_0000_DEAD_BEEF, 64'hFFFF_FFFF_3F80_0000,
          64'h0, 1'b1, 1'b1, 64'h0, 1'b1, 64'h0, 1'b1);
    drive("R1 single write", 64'h0, 64'h0, 64'h0, 1'b1, 1'b0,
          64'h1234_5678_3F80_0000, 1'b0, 64'h0, 1'b1);
    drive("R1 single write sNaN", 64'h0, 64'h0, 64'h0, 1'b1, 1'b0,
          64'h0000_0000_7F80_0001, 1'b0, 64'h0, 1'b1);
    drive("R2 double write", 64'h0, 64'h0, 64'h0, 1'b1, 1'b0,
          64'h7FF4_0000_DEAD_BEEF, 1'b1, 64'h0, 1'b1);
    drive("R9 neg qnan box", 64'h0, 64'h0, 64'h0, 1'b1, 1'b0,
          64'h0, 1'b0, 64'h0, 1'b1);
    drive("R3 single store", 64'h0, 64'h0, 64'h0, 1'b1, 1'b0, 64'h0, 1'b1,
          64'hDEAD_BEEF_0000_CAFE, 1'b0);
    drive("R3 single store boxed", 64'h0, 64'h0, 64'h0, 1'b1, 1'b0, 64'h0, 1'b1,
          64'hFFFF_FFFF_8000_0000, 1'b0);
    drive("R8 double store", 64'h0, 64'h0, 64'h0, 1'b1, 1'b0, 64'h0, 1'b1,
          64'h7FF0_0000_0000_0001, 1'b1);
    while (sb_q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule